// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register Front End

This block is the digital front end of a 12-bit voltage-output converter that is loaded over a three-wire serial link. A host lowers an active-low frame line and clocks one 16-bit word in, most significant bit first. The block takes each bit on a falling edge of the serial clock. A complete word is moved into a holding latch. From there it reaches the DAC code register in one of two ways. It goes across by itself when the frame closes if the load strobe is held low. Otherwise a later low-going pulse on the load strobe copies it across.

A second active-low frame line starts a readback. While it is low, the block shifts the current DAC code out on a serial data pin, framed as a 16-bit word. Each bit changes on a rising serial clock edge, so the host can take it on the next falling edge. All pins are sampled by the block's own system clock through a parameterised synchronizer, so a pin event takes effect a fixed number of system clocks later. The analog side is out of scope: the block presents only the 12-bit code.

Top module: `serdac_if`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, and right after it is released, `dac_code_o` is zero, `sdo_oe_o` is low and `sdo_o` is low. The holding latch is also zero.
- R2: A write frame is the interval in which `sync_ni` is low. Each falling edge of `sclk_i` in that interval shifts `sdin_i` in, most significant bit first. With the default `CODE_LSB` of 0, bits 11..0 of the 16-bit word form the code and bits 15..12 are ignored.
- R3: A frame that closes after fewer or more than 16 falling edges is discarded. Neither the holding latch nor `dac_code_o` changes, even with `ldac_ni` low.
- R4: If `ldac_ni` is low when `sync_ni` rises after exactly 16 bits, `dac_code_o` takes the new code.
- R5: If `ldac_ni` is high when a valid frame closes, only the holding latch is loaded and `dac_code_o` keeps its value. A later high-to-low transition of `ldac_ni` copies the latch into `dac_code_o`, with no serial clock activity needed.
- R6: `sync_ni` may stay low across two 8-bit bursts separated by an idle gap in `sclk_i`. The 16 bits are then taken as one word.
- R7: While `rben_ni` is low, `sdo_oe_o` is high. `sdo_o` presents a 16-bit word, most significant bit first, holding the DAC code at bits 11..0 and zeros at bits 15..12. The first bit appears when the frame opens, and each rising edge of `sclk_i` advances to the next bit.
- R8: Outside a readback frame, `sdo_oe_o` and `sdo_o` are both low.
- R9: A pin event affects the outputs exactly `SYNC_STAGES`+1 rising edges of `clk` after the edge that first samples it (3 with the defaults).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| sdin_i | input | 1 | Serial write data |
| sync_ni | input | 1 | Active-low write frame |
| ldac_ni | input | 1 | Active-low load strobe |
| rben_ni | input | 1 | Active-low readback frame |
| dac_code_o | output | 12 | Code presented to the converter |
| sdo_o | output | 1 | Serial readback data, low when idle |
| sdo_oe_o | output | 1 | High while readback data is driven |

## Verification
The assertions assume that the serial clock is slow against the system clock, so each level of `sclk_i` lasts for several system clocks and no edge is lost in the synchronizer. They also assume that a frame line never changes in the same system cycle as a serial clock edge. The stimulus keeps to this by holding every `sclk_i` level for four system clocks. It changes `sdin_i` only together with a rising serial clock edge. It moves `sync_ni`, `ldac_ni` and `rben_ni` only while `sclk_i` has been idle for several system clocks.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

   typedef struct packed {
      logic sclk;
      logic sdin;
      logic sync_n;
      logic ldac_n;
      logic rben_n;
   } pins_t;

   localparam pins_t PINS_IDLE = '{sclk: 1'b0, sdin: 1'b0, sync_n: 1'b1,
                                   ldac_n: 1'b1, rben_n: 1'b1};

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync
   import serdac_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  pins_t pins_in,
   output pins_t pins_cur,
   output pins_t pins_old
);

   pins_t chain [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("serdac_sync: STAGES must be at least 1");
      end
      for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gi] <= PINS_IDLE;
            else if (gi == 0) chain[gi] <= pins_in;
            else chain[gi] <= chain[(gi > 0) ? gi - 1 : 0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_old <= PINS_IDLE;
      else pins_old <= chain[STAGES-1];
   end

   assign pins_cur = chain[STAGES-1];

endmodule

// File: rtl/serdac_rx.sv
module serdac_rx
   import serdac_pkg::*;
#(
   parameter int FRAME_BITS = 16,
   localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  pins_t                 pins_cur,
   input  pins_t                 pins_old,
   output logic [FRAME_BITS-1:0] word,
   output logic [CNT_W-1:0]      bit_cnt,
   output logic                  word_ok,
   output logic                  ldac_fall
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_BITS + 1);

   logic sclk_fall;
   logic frame_end;

   always_comb begin
      sclk_fall = pins_old.sclk & ~pins_cur.sclk;
      frame_end = ~pins_old.sync_n & pins_cur.sync_n;
      word_ok   = frame_end && (bit_cnt == FULL);
      ldac_fall = pins_old.ldac_n & ~pins_cur.ldac_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word    <= '0;
         bit_cnt <= '0;
      end else if (pins_cur.sync_n) begin
         bit_cnt <= '0;
      end else if (sclk_fall) begin
         word <= {word[FRAME_BITS-2:0], pins_cur.sdin};
         if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/serdac_regs.sv
module serdac_regs #(
   parameter int DATA_W     = 12,
   parameter int FRAME_BITS = 16,
   parameter int CODE_LSB   = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [FRAME_BITS-1:0] word,
   input  logic                  word_ok,
   input  logic                  ldac_low,
   input  logic                  ldac_fall,
   output logic [DATA_W-1:0]     in_latch,
   output logic [DATA_W-1:0]     dac_code
);

   logic [DATA_W-1:0] code_new;

   assign code_new = word[CODE_LSB +: DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_latch <= '0;
      else if (word_ok) in_latch <= code_new;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dac_code <= '0;
      else if (word_ok && ldac_low) dac_code <= code_new;
      else if (ldac_fall) dac_code <= in_latch;
   end

endmodule

// File: rtl/serdac_tx.sv
module serdac_tx
   import serdac_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int FRAME_BITS = 16,
   parameter int CODE_LSB   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pins_t             pins_cur,
   input  pins_t             pins_old,
   input  logic [DATA_W-1:0] dac_code,
   output logic              sdo,
   output logic              sdo_oe
);

   logic [FRAME_BITS-1:0] rb_word;
   logic [FRAME_BITS-1:0] rb_sh;
   logic                  rb_start;
   logic                  sclk_rise;

   always_comb begin
      rb_word = '0;
      rb_word[CODE_LSB +: DATA_W] = dac_code;
      rb_start  = pins_old.rben_n & ~pins_cur.rben_n;
      sclk_rise = ~pins_old.sclk & pins_cur.sclk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb_sh  <= '0;
         sdo_oe <= 1'b0;
      end else begin
         sdo_oe <= ~pins_cur.rben_n;
         if (rb_start) rb_sh <= rb_word;
         else if (!pins_cur.rben_n && sclk_rise) rb_sh <= {rb_sh[FRAME_BITS-2:0], 1'b0};
      end
   end

   assign sdo = sdo_oe & rb_sh[FRAME_BITS-1];

endmodule

// File: rtl/serdac_if.sv
module serdac_if
   import serdac_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int FRAME_BITS  = 16,
   parameter int CODE_LSB    = 0,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdin_i,
   input  logic              sync_ni,
   input  logic              ldac_ni,
   input  logic              rben_ni,
   output logic [DATA_W-1:0] dac_code_o,
   output logic              sdo_o,
   output logic              sdo_oe_o
);

   generate
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("serdac_if: FRAME_BITS must be at least 2");
      end
      if (DATA_W < 1 || CODE_LSB < 0 || CODE_LSB + DATA_W > FRAME_BITS) begin : g_bad_field
         $error("serdac_if: code field does not fit in the frame");
      end
   endgenerate

   pins_t                 pins_raw;
   pins_t                 pins_cur;
   pins_t                 pins_old;
   logic [FRAME_BITS-1:0] word;
   logic [CNT_W-1:0]      bit_cnt;
   logic                  word_ok;
   logic                  ldac_fall;
   logic [DATA_W-1:0]     in_latch;

   assign pins_raw = '{sclk: sclk_i, sdin: sdin_i, sync_n: sync_ni,
                       ldac_n: ldac_ni, rben_n: rben_ni};

   serdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_in  (pins_raw),
      .pins_cur (pins_cur),
      .pins_old (pins_old)
   );

   serdac_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_cur  (pins_cur),
      .pins_old  (pins_old),
      .word      (word),
      .bit_cnt   (bit_cnt),
      .word_ok   (word_ok),
      .ldac_fall (ldac_fall)
   );

   serdac_regs #(.DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS), .CODE_LSB(CODE_LSB)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .word      (word),
      .word_ok   (word_ok),
      .ldac_low  (~pins_cur.ldac_n),
      .ldac_fall (ldac_fall),
      .in_latch  (in_latch),
      .dac_code  (dac_code_o)
   );

   serdac_tx #(.DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS), .CODE_LSB(CODE_LSB)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_cur (pins_cur),
      .pins_old (pins_old),
      .dac_code (dac_code_o),
      .sdo      (sdo_o),
      .sdo_oe   (sdo_oe_o)
   );

endmodule

// File: rtl/serdac_if_chk.sv
module serdac_if_chk #(
   parameter int DATA_W     = 12,
   parameter int FRAME_BITS = 16,
   parameter int CNT_W      = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] dac_code,
   input logic [DATA_W-1:0] in_latch,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              word_ok,
   input logic              ldac_fall,
   input logic              sdo,
   input logic              sdo_oe
);

   // R1: reset state seen at the ports
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r1: assert (dac_code == '0 && in_latch == '0 && !sdo_oe && !sdo)
            else $error("reset state not clear");
      end
   end

   p_latch_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(in_latch) |-> $past(word_ok));

   p_code_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |-> $past(word_ok || ldac_fall));

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_BITS + 1));

   p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo);

endmodule

bind serdac_if serdac_if_chk #(.DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dac_code  (dac_code_o),
   .in_latch  (in_latch),
   .bit_cnt   (bit_cnt),
   .word_ok   (word_ok),
   .ldac_fall (ldac_fall),
   .sdo       (sdo_o),
   .sdo_oe    (sdo_oe_o)
);

// File: tb/serdac_if_bench.sv
`timescale 1ns/1ps
module serdac_if_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk_i = 1'b0;
   logic        sdin_i = 1'b0;
   logic        sync_ni = 1'b1;
   logic        ldac_ni = 1'b0;
   logic        rben_ni = 1'b1;
   logic [11:0] dac_code_o;
   logic        sdo_o;
   logic        sdo_oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   serdac_if u_serdac_if (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_i     (sclk_i),
      .sdin_i     (sdin_i),
      .sync_ni    (sync_ni),
      .ldac_ni    (ldac_ni),
      .rben_ni    (rben_ni),
      .dac_code_o (dac_code_o),
      .sdo_o      (sdo_o),
      .sdo_oe_o   (sdo_oe_o)
   );

   // Behavioural reference: pins seen after a fixed 3-edge delay (R9)
   typedef struct {bit sclk; bit sdin; bit sync_n; bit ldac_n; bit rben_n;} pv_t;
   pv_t hq[$];
   int  m_word, m_cnt, m_latch, m_dac, m_sh;
   bit  m_oe;

   function automatic pv_t idle_pins();
      pv_t p;
      p.sclk = 0; p.sdin = 0; p.sync_n = 1; p.ldac_n = 1; p.rben_n = 1;
      return p;
   endfunction

   always @(posedge clk) begin
      pv_t now, cur, old;
      int  code;
      bit  wok;
      now.sclk = sclk_i; now.sdin = sdin_i; now.sync_n = sync_ni;
      now.ldac_n = ldac_ni; now.rben_n = rben_ni;
      if (!rst_n) begin
         hq.delete();
         for (int i = 0; i < 3; i++) hq.push_back(idle_pins());
         m_word = 0; m_cnt = 0; m_latch = 0; m_dac = 0; m_sh = 0; m_oe = 0;
      end else begin
         cur = hq[1];
         old = hq[2];
         // readback path uses the code held before this edge
         m_oe = !cur.rben_n;
         if (old.rben_n && !cur.rben_n) m_sh = m_dac;
         else if (!cur.rben_n && !old.sclk && cur.sclk) m_sh = (m_sh << 1) & 16'hFFFF;
         // register path
         wok = !old.sync_n && cur.sync_n && (m_cnt == 16);
         if (wok) begin
            code = m_word & 12'hFFF;
            m_latch = code;
            if (!cur.ldac_n) m_dac = code;
         end else if (old.ldac_n && !cur.ldac_n) begin
            m_dac = m_latch;
         end
         // shift path
         if (cur.sync_n) m_cnt = 0;
         else if (old.sclk && !cur.sclk) begin
            m_word = ((m_word << 1) | int'(cur.sdin)) & 16'hFFFF;
            if (m_cnt != 17) m_cnt++;
         end
         void'(hq.pop_back());
         hq.push_front(now);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (dac_code_o !== 12'(m_dac) || sdo_oe_o !== m_oe ||
             sdo_o !== (m_oe & m_sh[15])) begin
            errors++;
            $display("FAIL R9 cycle model: code=%h oe=%b sdo=%b expected code=%h oe=%b sdo=%b",
                     dac_code_o, sdo_oe_o, sdo_o, 12'(m_dac), m_oe, m_oe & m_sh[15]);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clock_bits(input logic [31:0] val, input int n);
      for (int i = 0; i < n; i++) begin
         sdin_i = val[n-1-i];
         sclk_i = 1'b1;
         tick(4);
         sclk_i = 1'b0;
         tick(4);
      end
   endtask

   task automatic send(input logic [31:0] val, input int n);
      sync_ni = 1'b0;
      tick(4);
      clock_bits(val, n);
      tick(4);
      sync_ni = 1'b1;
      tick(6);
   endtask

   task automatic send_split(input logic [15:0] val);
      sync_ni = 1'b0;
      tick(4);
      clock_bits({16'h0, val[15:8]}, 8);
      tick(20);
      clock_bits({24'h0, val[7:0]}, 8);
      tick(4);
      sync_ni = 1'b1;
      tick(6);
   endtask

   task automatic readback(input logic [11:0] exp);
      logic [15:0] got;
      rben_ni = 1'b0;
      tick(6);
      for (int i = 0; i < 16; i++) begin
         got[15-i] = sdo_o;
         chk("R7 oe", int'(sdo_oe_o), 1);
         sclk_i = 1'b1;
         tick(4);
         sclk_i = 1'b0;
         tick(4);
      end
      rben_ni = 1'b1;
      tick(6);
      chk("R7 readback word", int'(got), int'({4'h0, exp}));
      chk("R8 idle oe", int'(sdo_oe_o), 0);
      chk("R8 idle sdo", int'(sdo_o), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      chk("R1 code in reset", int'(dac_code_o), 0);
      chk("R1 oe in reset", int'(sdo_oe_o), 0);
      rst_n = 1'b1;
      tick(4);
      chk("R1 code after reset", int'(dac_code_o), 0);
      chk("R1 sdo after reset", int'(sdo_o), 0);

      // R2/R4: automatic update, upper nibble ignored
      send(32'hA5C3, 16);
      chk("R2 R4 auto update", int'(dac_code_o), 'h5C3);
      send(32'h0FFF, 16);
      chk("R2 all ones code", int'(dac_code_o), 'hFFF);
      send(32'hF001, 16);
      chk("R2 upper bits ignored", int'(dac_code_o), 'h001);

      // R3: short and long frames are dropped
      send(32'h3FF, 10);
      chk("R3 short frame", int'(dac_code_o), 'h001);
      send(32'h1ABCD, 17);
      chk("R3 long frame", int'(dac_code_o), 'h001);

      // R6: two bursts in one frame
      send_split(16'h1234);
      chk("R6 split word", int'(dac_code_o), 'h234);

      // R5: deferred load through the strobe
      ldac_ni = 1'b1;
      tick(6);
      send(32'h0ABC, 16);
      chk("R5 held in latch", int'(dac_code_o), 'h234);
      send(32'h0777, 9);
      ldac_ni = 1'b0;
      tick(6);
      chk("R5 R3 strobe copies latch", int'(dac_code_o), 'hABC);
      ldac_ni = 1'b1;
      tick(6);
      send(32'h0456, 16);
      chk("R5 second hold", int'(dac_code_o), 'hABC);
      ldac_ni = 1'b0;
      tick(2);
      chk("R9 not yet", int'(dac_code_o), 'hABC);
      tick(1);
      chk("R9 after three edges", int'(dac_code_o), 'h456);
      tick(4);

      // R7/R8: readback
      readback(12'h456);
      send(32'h0A5A, 16);
      readback(12'hA5A);
      chk("R8 no stray shift", int'(dac_code_o), 'hA5A);

      tick(10);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule